// File: doc/BRIEF.md
# Interrupt Source Enable Aggregator

This block keeps the enable state of every interrupt source in a controller where a single source can be governed by several independent enable fields and by membership in one or more groups. Each source owns a small saturating counter and a configured target value. Every enable event raises the counter and every disable event lowers it. The source counts as active only while its counter equals a non-zero target, which happens once all of its controlling enables are set.

Toggle events arrive on a simple port that carries a source index, the enable value and a group flag. A source that carries no vector of its own, or any source hit by a group event, passes the same enable value on to the source named in its link entry, marked as a group event. In this way a group's own entry walks along its member list one hop per clock cycle, and `walk_busy` is high while the walk runs. The link table, the targets and the vector-present flags are written through a configuration port before operation. Register decoding and priority arbitration sit outside this block.

Top module: `sie_aggregator`

## Requirements
- R1: After a synchronous reset, every bit of `src_active` is 0, `walk_busy` is 0, and every link, target and vector flag is 0.
- R2: An applied enable event raises the addressed source's counter by one, stopping at its target. An applied disable event lowers it by one, stopping at zero.
- R3: Bit i of `src_active` is 1 exactly when source i has a non-zero target and its counter equals that target.
- R4: A source whose link is 0 and which has either a zero target or no vector is reserved. An event that reaches it changes no counter and starts no walk.
- R5: When an applied event is a group event, or its source has no vector, and the source's link is non-zero, the linked source receives the same enable value as a group event on the next clock cycle. Link value 0 means "no link". `walk_busy` is 1 while such a forward is pending.
- R6: An event on `evt_valid` is taken only in a cycle where `walk_busy` is 0. An event offered while a walk is in progress is dropped and has no effect.
- R7: One accepted event applies to at most NUM_SRC sources in total, so a circular link table ends its walk after NUM_SRC hops.
- R8: A configuration write stores link, target and vector flag for `cfg_id` and clears that source's counter in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_id | input | ID_W | Source written by the configuration port |
| cfg_link | input | ID_W | Next source in the chain, 0 for none |
| cfg_max | input | CNT_W | Number of enables needed to activate |
| cfg_vec | input | 1 | Source has its own vector |
| evt_valid | input | 1 | Toggle event present |
| evt_id | input | ID_W | Source targeted by the event |
| evt_enable | input | 1 | 1 = enable, 0 = disable |
| evt_group | input | 1 | Event comes from a group |
| walk_busy | output | 1 | Chain walk in progress, new events are dropped |
| src_active | output | NUM_SRC | Per-source active flags |

## Verification
Plain sources with targets of one and two are driven through raising, over-raising, lowering below zero and raising again. These steps separate threshold detection from a simple mask bit, and saturation from wrap-around. Reserved sources with no vector or no target receive events, and their flags must stay unchanged. A group entry drives a three-long chain, and members are also hit directly by non-group and group events, which shows when forwarding applies and that each hop costs one busy cycle. A circular link table, an event offered mid-walk and a reconfiguration of an active source check the hop bound, the drop rule and the counter clear.

// File: rtl/sie_pkg.sv
package sie_pkg;

    localparam int SIE_NUM_SRC = 16;
    localparam int SIE_CNT_W   = 3;

    typedef enum logic {
        WALK_IDLE = 1'b0,
        WALK_RUN  = 1'b1
    } walk_state_e;

    typedef struct packed {
        logic enable;
        logic group;
    } hop_ctl_t;

    // A source without a successor that also lacks a target or a vector
    // can never be activated nor pass anything on.
    function automatic logic reserved_src(input logic link_zero,
                                          input logic max_zero,
                                          input logic has_vec);
        return link_zero && (max_zero || !has_vec);
    endfunction

    // Forward when the hop is group-driven or the source has no vector.
    function automatic logic forwards(input logic link_zero,
                                      input logic is_group,
                                      input logic has_vec);
        return !link_zero && (is_group || !has_vec);
    endfunction

endpackage

// File: rtl/sie_src_table.sv
module sie_src_table
    import sie_pkg::*;
#(
    parameter int NUM_SRC = SIE_NUM_SRC,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int CNT_W   = SIE_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [ID_W-1:0]  cfg_id,
    input  logic [ID_W-1:0]  cfg_link,
    input  logic [CNT_W-1:0] cfg_max,
    input  logic             cfg_vec,
    input  logic [ID_W-1:0]  rd_id,
    output logic [ID_W-1:0]  rd_link,
    output logic [CNT_W-1:0] rd_max,
    output logic             rd_vec,
    output logic [CNT_W-1:0] max_all [NUM_SRC]
);

    logic [ID_W-1:0]  link_q [NUM_SRC];
    logic [CNT_W-1:0] max_q  [NUM_SRC];
    logic [NUM_SRC-1:0] vec_q;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                link_q[g] <= '0;
                max_q[g]  <= '0;
                vec_q[g]  <= 1'b0;
            end else if (cfg_we && cfg_id == ID_W'(g)) begin
                link_q[g] <= cfg_link;
                max_q[g]  <= cfg_max;
                vec_q[g]  <= cfg_vec;
            end
        end
        assign max_all[g] = max_q[g];
    end

    always_comb begin
        rd_link = '0;
        rd_max  = '0;
        rd_vec  = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_id == ID_W'(i)) begin
                rd_link = link_q[i];
                rd_max  = max_q[i];
                rd_vec  = vec_q[i];
            end
        end
    end

endmodule

// File: rtl/sie_chain_walk.sv
module sie_chain_walk
    import sie_pkg::*;
#(
    parameter int NUM_SRC = SIE_NUM_SRC,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int CNT_W   = SIE_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic [ID_W-1:0]  evt_id,
    input  logic             evt_enable,
    input  logic             evt_group,
    input  logic [ID_W-1:0]  hop_link,
    input  logic [CNT_W-1:0] hop_max,
    input  logic             hop_vec,
    output logic             hop_apply,
    output logic [ID_W-1:0]  hop_id,
    output logic             hop_enable,
    output logic             busy
);

    localparam int HOP_W = $clog2(NUM_SRC) + 1;
    localparam logic [HOP_W-1:0] HOP_LAST = HOP_W'(NUM_SRC - 1);

    walk_state_e      state_q;
    logic [ID_W-1:0]  walk_id_q;
    hop_ctl_t         walk_ctl_q;
    logic [HOP_W-1:0] hops_q;

    hop_ctl_t cur_ctl;
    logic     hop_valid;
    logic     hop_reserved;
    logic     hop_fwd;
    logic     keep_walking;

    assign busy      = (state_q == WALK_RUN);
    assign hop_valid = busy || evt_valid;
    assign hop_id    = busy ? walk_id_q : evt_id;
    assign cur_ctl   = busy ? walk_ctl_q : hop_ctl_t'{enable: evt_enable, group: evt_group};
    assign hop_enable = cur_ctl.enable;

    assign hop_reserved = reserved_src(hop_link == '0, hop_max == '0, hop_vec);
    assign hop_apply    = hop_valid && !hop_reserved;
    assign hop_fwd      = hop_valid && forwards(hop_link == '0, cur_ctl.group, hop_vec);
    assign keep_walking = hop_fwd && (hops_q < HOP_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= WALK_IDLE;
            walk_id_q  <= '0;
            walk_ctl_q <= '0;
            hops_q     <= '0;
        end else if (hop_valid) begin
            if (keep_walking) begin
                state_q    <= WALK_RUN;
                walk_id_q  <= hop_link;
                walk_ctl_q <= hop_ctl_t'{enable: cur_ctl.enable, group: 1'b1};
                hops_q     <= hops_q + 1'b1;
            end else begin
                state_q <= WALK_IDLE;
                hops_q  <= '0;
            end
        end
    end

    // R5: a forwarding hop hands its link to the next cycle as a group hop
    a_r5_forward_next: assert property (@(posedge clk) disable iff (rst)
        (hop_valid && hop_link != '0 && (cur_ctl.group || !hop_vec) && hops_q < HOP_LAST)
        |=> (busy && hop_id == $past(hop_link) && hop_enable == $past(cur_ctl.enable)));

    // R5: a hop without a successor ends the walk
    a_r5_stop_at_null: assert property (@(posedge clk) disable iff (rst)
        (hop_valid && hop_link == '0) |=> !busy);

    // R7: walk length stays within the source count
    a_r7_hop_bound: assert property (@(posedge clk) disable iff (rst)
        hops_q <= HOP_LAST);

    // R6: while walking, the walker keeps its own source
    a_r6_busy_owns_hop: assert property (@(posedge clk) disable iff (rst)
        (busy && evt_valid) |-> (hop_id == walk_id_q));

endmodule

// File: rtl/sie_count_bank.sv
module sie_count_bank
    import sie_pkg::*;
#(
    parameter int NUM_SRC = SIE_NUM_SRC,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int CNT_W   = SIE_CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ID_W-1:0]    cfg_id,
    input  logic               hop_apply,
    input  logic [ID_W-1:0]    hop_id,
    input  logic               hop_enable,
    input  logic [CNT_W-1:0]   max_all [NUM_SRC],
    output logic [NUM_SRC-1:0] active
);

    logic [CNT_W-1:0] cnt_q [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic cfg_hit;
        logic hop_hit;

        assign cfg_hit = cfg_we && (cfg_id == ID_W'(g));
        assign hop_hit = hop_apply && (hop_id == ID_W'(g));

        always_ff @(posedge clk) begin
            if (rst || cfg_hit) begin
                cnt_q[g] <= '0;
            end else if (hop_hit) begin
                if (hop_enable && cnt_q[g] < max_all[g])
                    cnt_q[g] <= cnt_q[g] + 1'b1;
                else if (!hop_enable && cnt_q[g] != '0)
                    cnt_q[g] <= cnt_q[g] - 1'b1;
            end
        end

        assign active[g] = (max_all[g] != '0) && (cnt_q[g] == max_all[g]);

        // R2: counter never passes its target
        a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
            cnt_q[g] <= max_all[g]);

        // R2: an enable below target raises the count by one
        a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
            (hop_hit && !cfg_hit && hop_enable && cnt_q[g] < max_all[g])
            |=> cnt_q[g] == $past(cnt_q[g]) + 1'b1);

        // R4: a source untouched by hops and config keeps its count
        a_r4_untouched_stable: assert property (@(posedge clk) disable iff (rst)
            (!cfg_hit && !(hop_apply && hop_id == ID_W'(g))) |=> $stable(cnt_q[g]));

        // R8: configuration clears the count
        a_r8_cfg_clears: assert property (@(posedge clk) disable iff (rst)
            cfg_hit |=> cnt_q[g] == '0);
    end

endmodule

// File: rtl/sie_aggregator.sv
module sie_aggregator
    import sie_pkg::*;
#(
    parameter int NUM_SRC = SIE_NUM_SRC,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int CNT_W   = SIE_CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ID_W-1:0]    cfg_id,
    input  logic [ID_W-1:0]    cfg_link,
    input  logic [CNT_W-1:0]   cfg_max,
    input  logic               cfg_vec,
    input  logic               evt_valid,
    input  logic [ID_W-1:0]    evt_id,
    input  logic               evt_enable,
    input  logic               evt_group,
    output logic               walk_busy,
    output logic [NUM_SRC-1:0] src_active
);

    logic [ID_W-1:0]  hop_id;
    logic             hop_enable;
    logic             hop_apply;
    logic [ID_W-1:0]  hop_link;
    logic [CNT_W-1:0] hop_max;
    logic             hop_vec;
    logic [CNT_W-1:0] max_all [NUM_SRC];

    sie_src_table #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .CNT_W(CNT_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_id   (cfg_id),
        .cfg_link (cfg_link),
        .cfg_max  (cfg_max),
        .cfg_vec  (cfg_vec),
        .rd_id    (hop_id),
        .rd_link  (hop_link),
        .rd_max   (hop_max),
        .rd_vec   (hop_vec),
        .max_all  (max_all)
    );

    sie_chain_walk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .CNT_W(CNT_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .evt_valid  (evt_valid),
        .evt_id     (evt_id),
        .evt_enable (evt_enable),
        .evt_group  (evt_group),
        .hop_link   (hop_link),
        .hop_max    (hop_max),
        .hop_vec    (hop_vec),
        .hop_apply  (hop_apply),
        .hop_id     (hop_id),
        .hop_enable (hop_enable),
        .busy       (walk_busy)
    );

    sie_count_bank #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .CNT_W(CNT_W)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_id     (cfg_id),
        .hop_apply  (hop_apply),
        .hop_id     (hop_id),
        .hop_enable (hop_enable),
        .max_all    (max_all),
        .active     (src_active)
    );

    // R1: right after reset nothing is active and no walk runs
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (src_active == '0 && !walk_busy));

    // R3: an active source has a non-zero target
    a_r3_active_needs_target: assert property (@(posedge clk) disable iff (rst)
        (src_active[hop_id]) |-> (hop_max != '0));

endmodule

// File: tb/sie_aggregator_tb_top.sv
module sie_aggregator_tb_top;

    localparam int NUM_SRC = 16;
    localparam int ID_W    = 4;
    localparam int CNT_W   = 3;

    logic               clk = 1'b0;
    logic               rst;
    logic               cfg_we;
    logic [ID_W-1:0]    cfg_id;
    logic [ID_W-1:0]    cfg_link;
    logic [CNT_W-1:0]   cfg_max;
    logic               cfg_vec;
    logic               evt_valid;
    logic [ID_W-1:0]    evt_id;
    logic               evt_enable;
    logic               evt_group;
    logic               walk_busy;
    logic [NUM_SRC-1:0] src_active;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    sie_aggregator #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_link(cfg_link),
        .cfg_max(cfg_max), .cfg_vec(cfg_vec),
        .evt_valid(evt_valid), .evt_id(evt_id),
        .evt_enable(evt_enable), .evt_group(evt_group),
        .walk_busy(walk_busy), .src_active(src_active)
    );

    // entry: {id[3:0], enable, group, expected active[15:0], expected busy cycles[4:0]}
    localparam int NV = 18;
    localparam logic [26:0] VEC [NV] = '{
        {4'd1, 1'b1, 1'b0, 16'h0002, 5'd0},  // R2 R3 target 1
        {4'd2, 1'b1, 1'b0, 16'h0002, 5'd0},  // R3 one of two
        {4'd2, 1'b1, 1'b0, 16'h0006, 5'd0},  // R3 two of two
        {4'd2, 1'b1, 1'b0, 16'h0006, 5'd0},  // R2 saturate high
        {4'd2, 1'b0, 1'b0, 16'h0002, 5'd0},  // R2 leave target
        {4'd2, 1'b1, 1'b0, 16'h0006, 5'd0},  // R2 back
        {4'd3, 1'b1, 1'b0, 16'h0006, 5'd0},  // R4 no vector
        {4'd8, 1'b1, 1'b0, 16'h0006, 5'd0},  // R4 no target
        {4'd1, 1'b0, 1'b0, 16'h0004, 5'd0},  // R2 down
        {4'd1, 1'b0, 1'b0, 16'h0004, 5'd0},  // R2 saturate low
        {4'd1, 1'b1, 1'b0, 16'h0006, 5'd0},  // R2 no underflow
        {4'd4, 1'b1, 1'b0, 16'h0046, 5'd2},  // R5 group walk
        {4'd4, 1'b1, 1'b0, 16'h0066, 5'd2},  // R5 group walk again
        {4'd5, 1'b0, 1'b0, 16'h0046, 5'd0},  // R5 member direct, no forward
        {4'd5, 1'b1, 1'b1, 16'h0066, 5'd1},  // R5 member as group forwards
        {4'd4, 1'b0, 1'b0, 16'h0006, 5'd2},  // R5 group disable
        {4'd6, 1'b1, 1'b0, 16'h0046, 5'd0},  // R2 chain tail direct
        {4'd3, 1'b0, 1'b0, 16'h0046, 5'd0}   // R4 reserved disable
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_cfg(input int id, input int link, input int mx, input logic v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_id = ID_W'(id); cfg_link = ID_W'(link);
        cfg_max = CNT_W'(mx); cfg_vec = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [3:0] id, input logic en, input logic grp, output int nbusy);
        @(negedge clk);
        evt_valid = 1'b1; evt_id = id; evt_enable = en; evt_group = grp;
        @(negedge clk);
        evt_valid = 1'b0;
        nbusy = 0;
        while (walk_busy) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fails++; n_checks++;
                $display("FAIL watchdog actual=%0d expected<20000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
                $finish;
            end
        end
    end

    initial begin
        int nb;
        rst = 1'b1; cfg_we = 1'b0; cfg_id = '0; cfg_link = '0; cfg_max = '0; cfg_vec = 1'b0;
        evt_valid = 1'b0; evt_id = '0; evt_enable = 1'b0; evt_group = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 active", 32'(src_active), 32'h0);
        check("R1 busy", 32'(walk_busy), 32'h0);

        // R8 configuration: id, link, target, vector
        do_cfg(1, 0, 1, 1'b1);
        do_cfg(2, 0, 2, 1'b1);
        do_cfg(3, 0, 1, 1'b0);
        do_cfg(4, 5, 0, 1'b0);
        do_cfg(5, 6, 2, 1'b1);
        do_cfg(6, 0, 1, 1'b1);
        do_cfg(7, 0, 1, 1'b1);
        do_cfg(8, 0, 0, 1'b1);
        do_cfg(9, 10, 0, 1'b0);
        do_cfg(10, 9, 0, 1'b0);
        check("R1 R8 after config", 32'(src_active), 32'h0);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][26:23], VEC[i][22], VEC[i][21], nb);
            check($sformatf("R2/R3/R4/R5 vec%0d active", i), 32'(src_active), 32'(VEC[i][20:5]));
            check($sformatf("R5 vec%0d busy cycles", i), 32'(nb), 32'(VEC[i][4:0]));
        end

        // R7 circular chain, R6 event dropped mid-walk
        @(negedge clk);
        evt_valid = 1'b1; evt_id = 4'd9; evt_enable = 1'b1; evt_group = 1'b0;
        @(negedge clk);
        check("R5 loop busy", 32'(walk_busy), 32'h1);
        evt_id = 4'd7; evt_enable = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
        nb = 1;
        while (walk_busy) begin
            nb++;
            @(negedge clk);
        end
        check("R7 loop hop bound busy cycles", 32'(nb), 32'd15);
        check("R6 dropped event", 32'(src_active), 32'h0046);

        // R8 reconfiguring an active source clears it
        do_cfg(1, 0, 1, 1'b1);
        check("R8 cfg clears count", 32'(src_active), 32'h0044);
        send(4'd7, 1'b1, 1'b0, nb);
        check("R6 accepted after walk", 32'(src_active), 32'h00C4);
        check("R6 busy", 32'(nb), 32'd0);

        // R1 reset clears state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset active", 32'(src_active), 32'h0);
        send(4'd1, 1'b1, 1'b0, nb);
        check("R1 R4 table cleared", 32'(src_active), 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule